// File: doc/BRIEF.md
# HDLC Channel Bit-Enable Gate

This block stands between a framed T1 or E1 bit stream and a single HDLC controller. For every bit time it decides whether the bit on the line belongs to the channel that the controller is tied to. When it does, the block raises a one-cycle data-valid strobe that both the transmit and the receive side of the controller use. The framing logic upstream supplies the current position: the timeslot, the bit within the timeslot, the frame number and whether the bit is a T1 framing bit. The controller configuration supplies the channel select, an enable, a 56/64 kb/s choice and a mask of usable spare (Sa) bits.

Three selections do not take a whole timeslot. The first is 56 kb/s in T1, which drops the last bit of each octet. The second is a phantom select value of 31 in T1 extended-superframe mode, which ties controller 0 to the data-link framing bits. The third is E1 timeslot 0, which for controller 0 carries data only in the spare bits that are enabled. When the configuration does not connect the controller to anything, the block holds an interrupt-mask output high.

Top module: `hdlc_slot_gate`

## Requirements
- R1: While rst_n is low and in the first cycle after it, data_valid is 0 and irq_mask is 1.
- R2: data_valid is registered. It is 1 in the cycle after a clock edge where bit_strobe was 1 and the bit qualified, and it is 0 after any edge where bit_strobe was 0.
- R3: In T1 mode (e1_mode=0) with rate_64k=1 and ch_select 0..23, all eight bits (bit_pos 0..7) of the timeslot equal to ch_select qualify. Framing-bit times (fbit_slot=1) never qualify. A 24-frame multiframe therefore yields 192 strobes.
- R4: In T1 mode with rate_64k=0, bit_pos 7 (the last bit of the octet) is left out. A 24-frame multiframe yields 168 strobes.
- R5: In T1 mode, ch_select 24..30 connects nothing. ch_select 31 also connects nothing when esf_mode=0 or the instance is not controller 0. A select that connects nothing gives no strobes and irq_mask=1.
- R6: In T1 mode with esf_mode=1, ch_select=31 and controller 0, only framing bits (fbit_slot=1) in odd frame_num (frames numbered 1..24) qualify. This gives 12 strobes per multiframe.
- R7: In E1 mode, ch_select 1..31 takes all eight bits of the matching timeslot, whatever rate_64k and fbit_slot hold. A 16-frame multiframe yields 128 strobes.
- R8: In E1 mode with ch_select=0 on controller 0, a bit qualifies only in timeslot 0 of an odd frame_num, at bit_pos 3..7, and only when sa_enable[bit_pos-3] is 1. A 16-frame multiframe yields 8 times the number of set sa_enable bits.
- R9: In E1 mode, ch_select=0 connects nothing when sa_enable is all zero or the instance is not controller 0.
- R10: irq_mask is 1 exactly one cycle after an edge at which the configuration connected nothing, and 0 otherwise, regardless of bit_strobe.
- R11: ch_enable=0 connects nothing, whatever ch_select holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_strobe | input | 1 | One line bit is present this cycle |
| e1_mode | input | 1 | 1 = E1 framing, 0 = T1 framing |
| esf_mode | input | 1 | T1 extended superframe in use |
| fbit_slot | input | 1 | Current T1 bit is the framing bit |
| timeslot | input | 5 | Current timeslot number |
| bit_pos | input | 3 | Bit within timeslot, 0 = first on the line |
| frame_num | input | 5 | Frame number in the multiframe (T1 1..24, E1 0..15) |
| ch_enable | input | 1 | Controller connection enable |
| ch_select | input | 5 | Programmed channel select |
| rate_64k | input | 1 | T1: 1 = 64 kb/s, 0 = 56 kb/s |
| sa_enable | input | 5 | E1 spare-bit enables, bit k = bit_pos k+3 |
| data_valid | output | 1 | Registered qualified-bit strobe |
| irq_mask | output | 1 | Registered "not connected" interrupt mask |

## Verification
The assertions assume that upstream framing keeps frame_num within 1..24 in T1 and 0..15 in E1 whenever bit_strobe is high. One property checks this assumption directly. The random stimulus draws frame numbers only from those ranges and keeps timeslots below 24 in T1. Directed sweeps walk whole multiframes in real line order. The strobe counts they produce pin down each rate: 64, 56, the 4 kb/s data link and 4 kb/s per enabled spare bit.

// File: rtl/hdlc_gate_pkg.sv
`timescale 1ns/1ps
package hdlc_gate_pkg;
  localparam int TS_W     = 5;
  localparam int BIT_W    = 3;
  localparam int FRM_W    = 5;
  localparam int SA_N     = 5;
  localparam int SA_FIRST = 3;
  localparam int LSB_POS  = 7;

  typedef enum logic [1:0] {
    LINK_NONE = 2'd0,
    LINK_SLOT = 2'd1,
    LINK_FDL  = 2'd2,
    LINK_SA   = 2'd3
  } link_t;

  // Spare-bit lookup: bit_pos SA_FIRST+k is usable when mask[k] is set.
  function automatic logic sa_bit_pick(input logic [BIT_W-1:0] pos,
                                       input logic [SA_N-1:0] mask);
    logic r;
    r = 1'b0;
    for (int k = 0; k < SA_N; k++)
      if (pos == BIT_W'(SA_FIRST + k)) r = mask[k];
    return r;
  endfunction

  // T1 octet bit kept at the chosen rate (56k drops the last bit).
  function automatic logic t1_bit_kept(input logic rate64,
                                       input logic [BIT_W-1:0] pos);
    return rate64 | (pos != BIT_W'(LSB_POS));
  endfunction
endpackage

// File: rtl/hgate_link_select.sv
`timescale 1ns/1ps
module hgate_link_select
  import hdlc_gate_pkg::*;
#(
  parameter bit CTRL_ZERO   = 1'b1,
  parameter int T1_CHANNELS = 24,
  parameter int PHANTOM_SEL = 31
) (
  input  logic            e1_mode,
  input  logic            esf_mode,
  input  logic            ch_enable,
  input  logic [TS_W-1:0] ch_select,
  input  logic [SA_N-1:0] sa_enable,
  output link_t           link_kind
);
  logic fdl_ok, sa_ok;

  generate
    if (CTRL_ZERO) begin : g_ctrl0
      assign fdl_ok = esf_mode;
      assign sa_ok  = |sa_enable;
    end else begin : g_other
      assign fdl_ok = esf_mode & 1'b0;
      assign sa_ok  = (|sa_enable) & 1'b0;
    end
  endgenerate

  always_comb begin
    link_kind = LINK_NONE;
    if (ch_enable) begin
      if (e1_mode) begin
        if (ch_select != '0) link_kind = LINK_SLOT;
        else if (sa_ok)      link_kind = LINK_SA;
      end else begin
        if (ch_select < TS_W'(T1_CHANNELS))
          link_kind = LINK_SLOT;
        else if (ch_select == TS_W'(PHANTOM_SEL) && fdl_ok)
          link_kind = LINK_FDL;
      end
    end
  end
endmodule

// File: rtl/hgate_bit_match.sv
`timescale 1ns/1ps
module hgate_bit_match
  import hdlc_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  link_t            link_kind,
  input  logic             e1_mode,
  input  logic             fbit_slot,
  input  logic             rate_64k,
  input  logic [TS_W-1:0]  timeslot,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic             frame_odd,
  input  logic [TS_W-1:0]  ch_select,
  input  logic [SA_N-1:0]  sa_enable,
  output logic             hit
);
  logic slot_hit, fdl_hit, sa_hit;

  assign slot_hit = (e1_mode || !fbit_slot) && (timeslot == ch_select) &&
                    (e1_mode || t1_bit_kept(rate_64k, bit_pos));
  assign fdl_hit  = fbit_slot && frame_odd;
  assign sa_hit   = (timeslot == '0) && frame_odd &&
                    sa_bit_pick(bit_pos, sa_enable);

  always_comb begin
    unique case (link_kind)
      LINK_SLOT: hit = slot_hit;
      LINK_FDL:  hit = fdl_hit;
      LINK_SA:   hit = sa_hit;
      default:   hit = 1'b0;
    endcase
  end

  // R4: at 56 kb/s the last octet bit never qualifies
  a_r4_lsb_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !e1_mode && link_kind == LINK_SLOT && !rate_64k) |->
      (bit_pos != BIT_W'(LSB_POS)));

  // R6: data-link hits only on odd-frame framing bits
  a_r6_fdl_on_fbit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && link_kind == LINK_FDL) |-> (fbit_slot && frame_odd));

  // R8: spare-bit hits only in timeslot 0 of odd frames, positions 3..7
  a_r8_sa_window: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && link_kind == LINK_SA) |->
      (timeslot == '0 && frame_odd && bit_pos >= BIT_W'(SA_FIRST)));

  // R3: T1 timeslot hits never land on a framing bit
  a_r3_no_fbit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !e1_mode && link_kind == LINK_SLOT) |-> !fbit_slot);
endmodule

// File: rtl/hdlc_slot_gate.sv
`timescale 1ns/1ps
module hdlc_slot_gate
  import hdlc_gate_pkg::*;
#(
  parameter bit CTRL_ZERO   = 1'b1,
  parameter int T1_CHANNELS = 24,
  parameter int PHANTOM_SEL = 31,
  parameter int T1_FRAMES   = 24,
  parameter int E1_FRAMES   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             e1_mode,
  input  logic             esf_mode,
  input  logic             fbit_slot,
  input  logic [TS_W-1:0]  timeslot,
  input  logic [BIT_W-1:0] bit_pos,
  input  logic [FRM_W-1:0] frame_num,
  input  logic             ch_enable,
  input  logic [TS_W-1:0]  ch_select,
  input  logic             rate_64k,
  input  logic [SA_N-1:0]  sa_enable,
  output logic             data_valid,
  output logic             irq_mask
);
  link_t link_kind;
  logic  bit_hit;
  logic  not_connected;

  hgate_link_select #(
    .CTRL_ZERO(CTRL_ZERO), .T1_CHANNELS(T1_CHANNELS), .PHANTOM_SEL(PHANTOM_SEL)
  ) u_sel (
    .e1_mode(e1_mode), .esf_mode(esf_mode), .ch_enable(ch_enable),
    .ch_select(ch_select), .sa_enable(sa_enable), .link_kind(link_kind)
  );

  hgate_bit_match u_match (
    .clk(clk), .rst_n(rst_n), .link_kind(link_kind), .e1_mode(e1_mode),
    .fbit_slot(fbit_slot), .rate_64k(rate_64k), .timeslot(timeslot),
    .bit_pos(bit_pos), .frame_odd(frame_num[0]), .ch_select(ch_select),
    .sa_enable(sa_enable), .hit(bit_hit)
  );

  assign not_connected = (link_kind == LINK_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      irq_mask   <= 1'b1;
    end else begin
      data_valid <= bit_strobe & bit_hit;
      irq_mask   <= not_connected;
    end
  end

  // R2: a strobe out always follows a strobe in
  a_r2_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(bit_strobe));

  // R10: masked controller never sees data
  a_r10_mask_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !data_valid);

  // R11: a disabled connection is masked on the next cycle
  a_r11_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_enable && bit_hit == 1'b0) |=> irq_mask);

  // R6, R8: framing supplies frame numbers inside the multiframe
  a_r6_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (e1_mode ? (frame_num < FRM_W'(E1_FRAMES))
                            : (frame_num >= FRM_W'(1) &&
                               frame_num <= FRM_W'(T1_FRAMES))));
endmodule

// File: tb/hdlc_slot_gate_test.sv
`timescale 1ns/1ps
module hdlc_slot_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_strobe = 1'b0, e1_mode = 1'b0, esf_mode = 1'b0, fbit_slot = 1'b0;
  logic [4:0] timeslot = '0, frame_num = 5'd1, ch_select = '0, sa_enable = '0;
  logic [2:0] bit_pos = '0;
  logic ch_enable = 1'b0, rate_64k = 1'b1;
  logic data_valid, irq_mask, dv_other, irq_other;
  int checks = 0, errors = 0, seen = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_slot_gate uut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .e1_mode(e1_mode),
    .esf_mode(esf_mode), .fbit_slot(fbit_slot), .timeslot(timeslot),
    .bit_pos(bit_pos), .frame_num(frame_num), .ch_enable(ch_enable),
    .ch_select(ch_select), .rate_64k(rate_64k), .sa_enable(sa_enable),
    .data_valid(data_valid), .irq_mask(irq_mask));

  hdlc_slot_gate #(.CTRL_ZERO(1'b0)) uut_other (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .e1_mode(e1_mode),
    .esf_mode(esf_mode), .fbit_slot(fbit_slot), .timeslot(timeslot),
    .bit_pos(bit_pos), .frame_num(frame_num), .ch_enable(ch_enable),
    .ch_select(ch_select), .rate_64k(rate_64k), .sa_enable(sa_enable),
    .data_valid(dv_other), .irq_mask(irq_other));

  function automatic bit ref_conn(bit c0, bit e1, bit esf, bit en, int sel, int sa);
    if (!en) return 1'b0;
    if (e1) return (sel != 0) || (c0 && sa != 0);
    if (sel <= 23) return 1'b1;
    return (sel == 31) && esf && c0;
  endfunction

  function automatic bit ref_valid(bit c0, bit stb, bit e1, bit esf, bit fb, bit r64,
                                   int ts, int bp, int fn, bit en, int sel, int sa);
    if (!stb || !ref_conn(c0, e1, esf, en, sel, sa)) return 1'b0;
    if (e1 && sel == 0)
      return ts == 0 && (fn % 2) == 1 && bp >= 3 && ((sa >> (bp - 3)) & 1) != 0;
    if (e1) return ts == sel;
    if (sel == 31) return fb && (fn % 2) == 1;
    return !fb && ts == sel && (r64 || bp < 7);
  endfunction

  function automatic string tag_of(bit c0, bit e1, bit esf, bit en, int sel, bit r64);
    if (!en) return "R11";
    if (e1) return (sel != 0) ? "R7" : (c0 ? "R8" : "R9");
    if (sel <= 23) return r64 ? "R3" : "R4";
    if (sel == 31 && esf && c0) return "R6";
    return "R5";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(bit stb, bit e1, bit esf, bit fb, bit r64, int ts, int bp,
                       int fn, bit en, int sel, int sa);
    @(negedge clk);
    bit_strobe = stb; e1_mode = e1; esf_mode = esf; fbit_slot = fb;
    rate_64k = r64; timeslot = 5'(ts); bit_pos = 3'(bp); frame_num = 5'(fn);
    ch_enable = en; ch_select = 5'(sel); sa_enable = 5'(sa);
    @(posedge clk); #1;
    check(tag_of(1, e1, esf, en, sel, r64), "data_valid", int'(data_valid),
          int'(ref_valid(1, stb, e1, esf, fb, r64, ts, bp, fn, en, sel, sa)));
    check("R10", "irq_mask", int'(irq_mask), int'(!ref_conn(1, e1, esf, en, sel, sa)));
    check(tag_of(0, e1, esf, en, sel, r64), "other data_valid", int'(dv_other),
          int'(ref_valid(0, stb, e1, esf, fb, r64, ts, bp, fn, en, sel, sa)));
    check(tag_of(0, e1, esf, en, sel, r64), "other irq_mask", int'(irq_other),
          int'(!ref_conn(0, e1, esf, en, sel, sa)));
    if (data_valid) seen++;
  endtask

  task automatic t1_multiframe(bit esf, bit r64, bit en, int sel);
    seen = 0;
    for (int f = 1; f <= 24; f++) begin
      apply(1, 0, esf, 1, r64, 0, 0, f, en, sel, 0);
      for (int t = 0; t < 24; t++)
        for (int b = 0; b < 8; b++) apply(1, 0, esf, 0, r64, t, b, f, en, sel, 0);
    end
    apply(0, 0, esf, 0, r64, 0, 0, 1, en, sel, 0);
  endtask

  task automatic e1_multiframe(bit r64, bit en, int sel, int sa);
    seen = 0;
    for (int f = 0; f < 16; f++)
      for (int t = 0; t < 32; t++)
        for (int b = 0; b < 8; b++) apply(1, 1, 0, 0, r64, t, b, f, en, sel, sa);
    apply(0, 1, 0, 0, r64, 0, 0, 0, en, sel, sa);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ch_enable = 1'b1; ch_select = 5'd5; bit_strobe = 1'b1; timeslot = 5'd5;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "data_valid in reset", int'(data_valid), 0);
    check("R1", "irq_mask in reset", int'(irq_mask), 1);
    @(negedge clk); rst_n = 1'b1; bit_strobe = 1'b0;
    @(posedge clk); #1;
    check("R1", "data_valid after reset", int'(data_valid), 0);

    t1_multiframe(0, 1, 1, 5);   check("R3", "64k strobes", seen, 192);
    t1_multiframe(0, 0, 1, 5);   check("R4", "56k strobes", seen, 168);
    t1_multiframe(1, 1, 1, 31);  check("R6", "data link strobes", seen, 12);
    t1_multiframe(0, 1, 1, 31);  check("R5", "phantom without ESF", seen, 0);
    check("R5", "phantom without ESF mask", int'(irq_mask), 1);
    t1_multiframe(1, 1, 1, 27);  check("R5", "select 27 strobes", seen, 0);
    e1_multiframe(0, 1, 9, 0);   check("R7", "E1 slot 9 strobes", seen, 128);
    e1_multiframe(1, 1, 0, 5'b10110); check("R8", "three Sa bits", seen, 24);
    e1_multiframe(1, 1, 0, 5'b11111); check("R8", "five Sa bits", seen, 40);
    e1_multiframe(1, 1, 0, 5'b00001); check("R8", "one Sa bit", seen, 8);
    e1_multiframe(1, 1, 0, 0);   check("R9", "no Sa bits", seen, 0);
    check("R9", "no Sa bits mask", int'(irq_mask), 1);
    e1_multiframe(1, 0, 9, 0);   check("R11", "disabled strobes", seen, 0);
    check("R11", "disabled mask", int'(irq_mask), 1);

    for (int n = 0; n < 4000; n++) begin
      bit e1, fb;
      int ts, fn, sel;
      e1 = 1'($urandom_range(0, 1));
      ts = e1 ? $urandom_range(0, 31) : $urandom_range(0, 23);
      fn = e1 ? $urandom_range(0, 15) : $urandom_range(1, 24);
      fb = e1 ? 1'($urandom_range(0, 1)) : ($urandom_range(0, 7) == 0);
      sel = ($urandom_range(0, 1) == 1) ? ts : $urandom_range(0, 31);
      if ($urandom_range(0, 7) == 0) sel = e1 ? 0 : 31;
      apply(1'($urandom_range(0, 1)), e1, 1'($urandom_range(0, 1)), fb,
            1'($urandom_range(0, 1)), ts, $urandom_range(0, 7), fn,
            ($urandom_range(0, 9) != 0), sel, $urandom_range(0, 31));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule